// File: doc/BRIEF.md
# USB Supply Plug-Detect Control Register

This block is one byte of control and status for the USB supply of a microcontroller. Two analog comparators compare the USB supply rail against an upper and a lower threshold. Their outputs reach the block asynchronously. The block synchronizes them and reports each comparator level as a read-only flag. It also keeps a plug flag with hysteresis: the flag turns on above the upper threshold, turns off below the lower threshold, and holds its value in between.

When the cable is plugged in, the rising plug flag can latch a level interrupt if the interrupt is enabled. Software clears that interrupt by writing the register with a clear bit set. The same register holds a 2-bit regulator voltage code, a regulator power-on bit and a detector power-down bit. Powering the detector down forces all three status flags to 1.

Top module: `usb_supply_ctl`

## Requirements
- R1: After reset the register reads 00h, and `vsel`, `reg_on`, `det_pwrdn` and `irq` are all 0.
- R2: Read bit 7 shows the upper comparator level after a two-flop synchronizer. A change on `cmp_hi_async` is not visible after one clock edge and is visible after the second.
- R3: Read bit 6 shows the lower comparator level after the same synchronizer. It is 1 while the supply is above the lower threshold.
- R4: Read bit 5 is the plug flag. It is set when the synchronized upper level is 1 and cleared when the synchronized lower level is 0. Otherwise it keeps its value. It updates one clock after the synchronized level changes, so three edges after the comparator input changes.
- R5: If the synchronized upper level is 1 while the lower level is 0, the plug flag is set.
- R6: If bit 4 (interrupt enable) is 1 when the plug flag goes from 0 to 1, a pending bit is set. `irq` is that pending bit. A 1-to-0 plug transition, or any transition while bit 4 is 0, sets nothing.
- R7: The pending bit stays set until a write with data bit 5 equal to 1. If a plug rising edge occurs in the same clock as that write, the pending bit stays set.
- R8: While bit 1 (detector disable) is 1, bits 7 to 5 read 1 and `det_pwrdn` is 1. No interrupt is requested while the detector is disabled. Re-enabling it raises no interrupt, because the plug flag restarts from the comparator state.
- R9: Bits 3:2 drive `vsel`, with codes 00 = 3.5 V, 01 = 3.4 V, 10 = 3.3 V and 11 = 2.8 V. Bit 0 drives `reg_on`, where 0 means the regulator is shut down.
- R10: A write stores data bits 4 to 0 in the register. Data bits 7 to 5 never change read bits 7 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| cmp_hi_async | input | 1 | Upper-threshold comparator, asynchronous |
| cmp_lo_async | input | 1 | Lower-threshold comparator, asynchronous |
| vsel | output | 2 | Regulator voltage code |
| reg_on | output | 1 | Regulator power-on |
| det_pwrdn | output | 1 | Detector power-down |
| irq | output | 1 | Level interrupt (pending plug-in) |

## Verification
The bench builds the block with the default of two synchronizer stages. With that depth the latency of the status flags, and of the plug latch behind them, can be checked edge by edge. It also lets the bench line up a clear write with the exact edge on which the plug flag rises, to test the priority between them. Comparator patterns walk the hysteresis band, including the inconsistent pair. Directed sequences cover interrupt enable, clearing, and disabling and re-enabling the detector.

// File: rtl/usbpwr_pkg.sv
package usbpwr_pkg;

    // Bit positions that software decodes.
    localparam int BIT_HI   = 7;
    localparam int BIT_LO   = 6;
    localparam int BIT_PLUG = 5;
    localparam int BIT_CLR  = 5;

    typedef enum logic [1:0] {
        VOUT_3V5 = 2'b00,
        VOUT_3V4 = 2'b01,
        VOUT_3V3 = 2'b10,
        VOUT_2V8 = 2'b11
    } vout_e;

    typedef struct packed {
        logic  plug_ie;
        vout_e vout;
        logic  det_off;
        logic  reg_en;
    } ctrl_t;

    typedef struct packed {
        logic above_hi;
        logic above_lo;
        logic plugged;
    } status_t;

    // Hysteresis: the upper comparator wins, then the lower one, else hold.
    function automatic logic plug_next(input logic hi, input logic lo, input logic cur);
        if (hi)
            return 1'b1;
        else if (!lo)
            return 1'b0;
        else
            return cur;
    endfunction

    function automatic logic [7:0] pack_reg(input status_t st, input ctrl_t c);
        return {st, c};
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [4:0] d);
        ctrl_t c;
        c.plug_ie = d[4];
        c.vout    = vout_e'(d[3:2]);
        c.det_off = d[1];
        c.reg_en  = d[0];
        return c;
    endfunction

endpackage

// File: rtl/usbpwr_sync.sv
module usbpwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stage_q[0] <= '0;
        else
            stage_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= '0;
            else
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[LAST];
endmodule

// File: rtl/usbpwr_plug.sv
module usbpwr_plug
    import usbpwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hi_s,
    input  logic lo_s,
    input  logic det_off,
    output logic plug_q,
    output logic plug_rise
);
    logic det_off_d;
    logic nxt;

    assign nxt = plug_next(hi_s, lo_s, plug_q);

    // An edge counts only while the detector is on and was on in the previous cycle.
    assign plug_rise = nxt & ~plug_q & ~det_off & ~det_off_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            plug_q    <= 1'b0;
            det_off_d <= 1'b0;
        end else begin
            det_off_d <= det_off;
            // While powered down, restart from the upper comparator level.
            plug_q    <= det_off ? hi_s : nxt;
        end
    end
endmodule

// File: rtl/usbpwr_regs.sv
module usbpwr_regs
    import usbpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [5:0] wr_lo,
    input  logic       plug_rise,
    output ctrl_t      ctrl_q,
    output logic       pend_q
);
    logic clr_req;
    logic set_req;

    assign clr_req = wr_en & wr_lo[BIT_CLR];
    assign set_req = plug_rise & ctrl_q.plug_ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr_en)
                ctrl_q <= unpack_ctrl(wr_lo[4:0]);
            if (set_req)
                pend_q <= 1'b1;
            else if (clr_req)
                pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_supply_ctl.sv
module usb_supply_ctl
    import usbpwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cmp_hi_async,
    input  logic       cmp_lo_async,
    output logic [1:0] vsel,
    output logic       reg_on,
    output logic       det_pwrdn,
    output logic       irq
);
    logic [1:0] cmp_sync;
    logic       hi_sync;
    logic       lo_sync;
    logic       plug_raw;
    logic       plug_rise;
    logic       pend_q;
    ctrl_t      ctrl_q;
    status_t    status_vis;
    logic       unused_wr_hi;

    assign unused_wr_hi = ^wr_data[7:6];

    usbpwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({cmp_hi_async, cmp_lo_async}),
        .q_sync  (cmp_sync)
    );

    assign hi_sync = cmp_sync[1];
    assign lo_sync = cmp_sync[0];

    usbpwr_plug u_plug (
        .clk       (clk),
        .rst       (rst),
        .hi_s      (hi_sync),
        .lo_s      (lo_sync),
        .det_off   (ctrl_q.det_off),
        .plug_q    (plug_raw),
        .plug_rise (plug_rise)
    );

    usbpwr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_lo     (wr_data[5:0]),
        .plug_rise (plug_rise),
        .ctrl_q    (ctrl_q),
        .pend_q    (pend_q)
    );

    always_comb begin
        if (ctrl_q.det_off)
            status_vis = '1;
        else
            status_vis = '{above_hi: hi_sync, above_lo: lo_sync, plugged: plug_raw};
    end

    assign rd_data   = pack_reg(status_vis, ctrl_q);
    assign vsel      = ctrl_q.vout;
    assign reg_on    = ctrl_q.reg_en;
    assign det_pwrdn = ctrl_q.det_off;
    assign irq       = pend_q;
endmodule

// File: rtl/usb_supply_ctl_chk.sv
module usb_supply_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [5:0] wr_lo,
    input logic [7:0] rd_data,
    input logic [1:0] vsel,
    input logic       reg_on,
    input logic       det_pwrdn,
    input logic       irq,
    input logic       hi_s,
    input logic       lo_s,
    input logic       plug_q
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !irq && vsel == 2'b00 && !reg_on && !det_pwrdn));

    a_r4_set_above_hi: assert property (@(posedge clk) disable iff (rst)
        hi_s |=> plug_q);

    a_r4_clear_below_lo: assert property (@(posedge clk) disable iff (rst)
        (!hi_s && !lo_s) |=> !plug_q);

    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(rd_data[4]) && rd_data[5] && !$past(rd_data[1])));

    a_r7_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && wr_lo[5])) |=> irq);

    a_r8_forced_high: assert property (@(posedge clk) disable iff (rst)
        rd_data[1] |-> (rd_data[7:5] == 3'b111 && det_pwrdn));

    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[4:0] == $past(wr_lo[4:0])));
endmodule

bind usb_supply_ctl usb_supply_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_lo     (wr_data[5:0]),
    .rd_data   (rd_data),
    .vsel      (vsel),
    .reg_on    (reg_on),
    .det_pwrdn (det_pwrdn),
    .irq       (irq),
    .hi_s      (hi_sync),
    .lo_s      (lo_sync),
    .plug_q    (plug_raw)
);

// File: tb/usb_supply_ctl_bench.sv
module usb_supply_ctl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmp_hi = 1'b0;
    logic       cmp_lo = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] vsel;
    logic       reg_on;
    logic       det_pwrdn;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    usb_supply_ctl u_usb_supply_ctl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .cmp_hi_async (cmp_hi),
        .cmp_lo_async (cmp_lo),
        .vsel         (vsel),
        .reg_on       (reg_on),
        .det_pwrdn    (det_pwrdn),
        .irq          (irq)
    );

    // {hi, lo, expected bit7, bit6, plug}
    localparam logic [4:0] VEC [10] = '{
        5'b00_000, 5'b01_010, 5'b11_111, 5'b01_011, 5'b00_000,
        5'b01_010, 5'b10_101, 5'b01_011, 5'b11_111, 5'b00_000
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic drive(input logic hi, input logic lo);
        cmp_hi = hi;
        cmp_lo = lo;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 outs", {4'h0, vsel, reg_on, det_pwrdn}, 8'h00);
        chk("R1 irq", {7'h0, irq}, 8'h00);

        // R2/R4 latency: input changes before edge k
        drive(1, 1);
        step(1);
        chk("R2 not yet", {5'h0, rd_data[7:5]}, 8'h00);
        step(1);
        chk("R2 R3 visible", {5'h0, rd_data[7:5]}, 8'h06);
        step(1);
        chk("R4 plug after sync", {5'h0, rd_data[7:5]}, 8'h07);
        chk("R6 no irq when disabled", {7'h0, irq}, 8'h00);
        drive(0, 0);
        step(4);

        // Table walk over the hysteresis band (R3 R4 R5)
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][4], VEC[i][3]);
            step(4);
            chk("R3 R4 R5 table", {5'h0, rd_data[7:5]}, {5'h0, VEC[i][2:0]});
        end

        // R9 / R10 writes
        wr(8'hFD);
        chk("R10 top bits ignored", rd_data, 8'h1D);
        chk("R9 vsel 2.8V reg on", {5'h0, vsel, reg_on}, 8'h07);
        wr(8'h08);
        chk("R9 vsel 3.3V reg off", {5'h0, vsel, reg_on}, 8'h04);
        chk("R10 rw", rd_data, 8'h08);

        // R6 plug-in with enable
        wr(8'h10);
        drive(1, 1);
        step(4);
        chk("R6 irq on plug", {7'h0, irq}, 8'h01);
        chk("R6 rd", rd_data, 8'hF0);
        drive(0, 1);
        step(4);
        chk("R4 hold in band", {5'h0, rd_data[7:5]}, 8'h03);
        drive(0, 0);
        step(4);
        chk("R7 sticky", {7'h0, irq}, 8'h01);
        wr(8'h30);
        chk("R7 cleared", {7'h0, irq}, 8'h00);
        chk("R7 rd", rd_data, 8'h10);

        // R6 unplug does not request
        drive(1, 1);
        step(4);
        wr(8'h30);
        drive(0, 0);
        step(4);
        chk("R6 no irq on unplug", {7'h0, irq}, 8'h00);

        // R7 priority: clear write on the same edge the plug flag rises
        drive(1, 1);
        step(2);
        wr(8'h30);
        chk("R7 rise beats clear", {6'h0, rd_data[5], irq}, 8'h03);
        wr(8'h30);
        chk("R7 clear after", {7'h0, irq}, 8'h00);

        // R8 detector disable
        drive(0, 0);
        step(4);
        wr(8'h12);
        chk("R8 forced high", rd_data, 8'hF2);
        chk("R8 pwrdn", {7'h0, det_pwrdn}, 8'h01);
        drive(1, 1);
        step(4);
        chk("R8 no irq while off", {7'h0, irq}, 8'h00);
        wr(8'h10);
        step(2);
        chk("R8 re-enable rd", rd_data, 8'hF0);
        chk("R8 re-enable no irq", {6'h0, det_pwrdn, irq}, 8'h00);
        drive(0, 0);
        step(4);
        wr(8'h12);
        wr(8'h10);
        step(2);
        chk("R8 restart low", rd_data, 8'h10);
        chk("R8 restart no irq", {7'h0, irq}, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule